// File: doc/BRIEF.md
# External Bus Hold Handshake Controller

This block decides who drives an external memory bus: the local memory controller, or an external master that asks for the bus. The external master pulls an active-low request line low. Before it answers, the block lets the local side finish whatever it is doing. It then turns off every bus driver, and only after that does it pull the active-low grant line low. When the request line goes high again, the block turns the bus drivers back on first, and only then releases the grant.

Two configuration inputs change this sequence. The first makes sure an SDRAM run of the local controller reaches a minimum number of accesses before the bus is given away. The second makes the block ignore requests entirely. A stall output tells the local controller to start no new transfer while a handover is underway.

Each fixed delay in the handshake is a parameter counted in CPU clock cycles. The request line passes through a two-stage synchronizer before the state machine sees it.

Top module: `bus_hold_ctrl`

## Requirements
- R1: After reset, `hold_ack_n` is 1, `bus_drive_en` is 1 and `lc_stall` is 0.
- R2: While the block owns the bus and `cfg_block_hold` is 0, `lc_stall` rises on the third rising edge at which `hold_req_n` is sampled low.
- R3: With `lc_busy` low and no partial SDRAM run pending, `bus_drive_en` falls exactly HIZ_DLY (default 4) rising edges after `lc_stall` rises.
- R4: `hold_ack_n` falls exactly ACK_DLY (default 2) edges after `bus_drive_en` falls. `hold_ack_n` never falls unless `bus_drive_en` is low in that cycle and also in the cycle before.
- R5: While `lc_busy` is 1, `bus_drive_en` stays high. Once the HIZ_DLY wait has elapsed, it falls on the first edge at which `lc_busy` is sampled 0.
- R6: Each cycle with `lc_sdram_acc`=1 counts as one SDRAM access. A run of accesses ends once it reaches MIN_BURST (default 8). With `cfg_min_burst`=1 and 1 to MIN_BURST-1 accesses counted, the bus is not released until the count reaches MIN_BURST. With `cfg_min_burst`=0, a partial count has no effect on timing.
- R7: While `cfg_block_hold` is 1 and the block owns the bus, a low `hold_req_n` is ignored: `lc_stall` stays 0, and `hold_ack_n` and `bus_drive_en` stay 1.
- R8: After the grant, and for as long as `hold_req_n` stays low, `hold_ack_n` stays 0 and `bus_drive_en` stays 0.
- R9: `bus_drive_en` rises on the fourth edge at which `hold_req_n` is sampled high after a grant. `hold_ack_n` rises, and `lc_stall` falls, REL_DLY (default 2) edges later. `hold_ack_n` never rises unless `bus_drive_en` is high in that cycle and in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_req_n | input | 1 | Active-low bus request from the external master (asynchronous) |
| cfg_block_hold | input | 1 | When 1, bus requests are ignored |
| cfg_min_burst | input | 1 | When 1, a started SDRAM run must reach MIN_BURST accesses before release |
| lc_busy | input | 1 | Local controller has a transfer in progress |
| lc_sdram_acc | input | 1 | One-cycle strobe per SDRAM access |
| hold_ack_n | output | 1 | Active-low bus grant |
| bus_drive_en | output | 1 | 1 = bus drivers enabled, 0 = all bus pins high impedance |
| lc_stall | output | 1 | Local controller must start no new transfer |

## Verification
The assertions check on every cycle that the drivers turn off before the grant falls and turn back on before the grant rises. They also check that drivers never turn off right after a busy cycle or while a required SDRAM run is short, that a blocked request never raises the stall, and that a grant is held while the request stays low. Only the bench's scenarios can show the exact cycle counts for each edge of the handshake. The same holds for the length of the wait behind a long transfer or a partial SDRAM run, and for the effect of a count left below MIN_BURST when `cfg_min_burst` is clear.

// File: rtl/bhh_pkg.sv
package bhh_pkg;

    typedef enum logic [2:0] {
        ST_OWN_BUS       = 3'd0,
        ST_DRAIN         = 3'd1,
        ST_TRISTATE_WAIT = 3'd2,
        ST_GRANTED       = 3'd3,
        ST_REDRIVE_WAIT  = 3'd4
    } hold_state_e;

    typedef struct packed {
        logic drive_en;
        logic ack_n;
        logic stall;
    } hold_out_t;

    // Output pattern for each handover phase
    function automatic hold_out_t decode_outputs(hold_state_e s);
        hold_out_t o;
        case (s)
            ST_OWN_BUS:       o = '{drive_en: 1'b1, ack_n: 1'b1, stall: 1'b0};
            ST_DRAIN:         o = '{drive_en: 1'b1, ack_n: 1'b1, stall: 1'b1};
            ST_TRISTATE_WAIT: o = '{drive_en: 1'b0, ack_n: 1'b1, stall: 1'b1};
            ST_GRANTED:       o = '{drive_en: 1'b0, ack_n: 1'b0, stall: 1'b1};
            ST_REDRIVE_WAIT:  o = '{drive_en: 1'b1, ack_n: 1'b0, stall: 1'b1};
            default:          o = '{drive_en: 1'b1, ack_n: 1'b1, stall: 1'b0};
        endcase
        return o;
    endfunction

    function automatic int max4(int a, int b, int c, int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/bhh_sync.sv
module bhh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bhh_burst_tracker.sv
module bhh_burst_tracker #(
    parameter int MIN_BURST = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic acc,
    input  logic clear,
    output logic burst_ok
);
    localparam int CW = $clog2(MIN_BURST + 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_BURST);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)            run_cnt <= '0;
        else if (acc)                run_cnt <= (run_cnt == FULL) ? FULL : run_cnt + 1'b1;
        else if (run_cnt == FULL)    run_cnt <= '0;   // completed run closes
    end

    assign burst_ok = !enable || (run_cnt == '0) || (run_cnt == FULL);

    // R6: the run counter never exceeds the minimum run length
    p_run_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= FULL);
endmodule

// File: rtl/bhh_fsm.sv
module bhh_fsm
    import bhh_pkg::*;
#(
    parameter int HIZ_DLY = 4,
    parameter int ACK_DLY = 2,
    parameter int DRV_DLY = 2,
    parameter int REL_DLY = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hold_n_s,
    input  logic        block,
    input  logic        busy,
    input  logic        burst_ok,
    output hold_state_e state,
    output hold_out_t   outs
);
    localparam int MAXD = max4(HIZ_DLY, ACK_DLY, DRV_DLY, REL_DLY);
    localparam int CW   = $clog2(MAXD + 1);
    localparam logic [CW-1:0] HIZ_LAST = CW'(HIZ_DLY - 1);
    localparam logic [CW-1:0] ACK_LAST = CW'(ACK_DLY - 1);
    localparam logic [CW-1:0] DRV_LAST = CW'(DRV_DLY - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(REL_DLY - 1);

    hold_state_e nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        case (state)
            ST_OWN_BUS: begin
                cnt_nxt = '0;
                if (!hold_n_s && !block) nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (hold_n_s || block) begin
                    nxt     = ST_OWN_BUS;
                    cnt_nxt = '0;
                end else if (cnt >= HIZ_LAST && !busy && burst_ok) begin
                    nxt     = ST_TRISTATE_WAIT;
                    cnt_nxt = '0;
                end else if (cnt < HIZ_LAST) begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_TRISTATE_WAIT: begin
                if (cnt == ACK_LAST) begin
                    nxt     = ST_GRANTED;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_GRANTED: begin
                if (!hold_n_s) begin
                    cnt_nxt = '0;
                end else if (cnt == DRV_LAST) begin
                    nxt     = ST_REDRIVE_WAIT;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_REDRIVE_WAIT: begin
                if (cnt == REL_LAST) begin
                    nxt     = ST_OWN_BUS;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: begin
                nxt     = ST_OWN_BUS;
                cnt_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OWN_BUS;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    assign outs = decode_outputs(state);

    // R8: a held request keeps the grant in place
    p_hold_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GRANTED && !hold_n_s) |=> state == ST_GRANTED);

    // R6: drivers turn off only when the SDRAM run rule allowed it
    p_burst_ok_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.drive_en) |-> $past(burst_ok));
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
    import bhh_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIZ_DLY     = 4,
    parameter int ACK_DLY     = 2,
    parameter int DRV_DLY     = 2,
    parameter int REL_DLY     = 2,
    parameter int MIN_BURST   = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req_n,
    input  logic cfg_block_hold,
    input  logic cfg_min_burst,
    input  logic lc_busy,
    input  logic lc_sdram_acc,
    output logic hold_ack_n,
    output logic bus_drive_en,
    output logic lc_stall
);
    logic        hold_n_s;
    logic        burst_ok;
    hold_state_e state;
    hold_out_t   outs;

    bhh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hold_req_n),
        .q   (hold_n_s)
    );

    bhh_burst_tracker #(.MIN_BURST(MIN_BURST)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .enable   (cfg_min_burst),
        .acc      (lc_sdram_acc),
        .clear    (state == ST_GRANTED),
        .burst_ok (burst_ok)
    );

    bhh_fsm #(
        .HIZ_DLY (HIZ_DLY),
        .ACK_DLY (ACK_DLY),
        .DRV_DLY (DRV_DLY),
        .REL_DLY (REL_DLY)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hold_n_s (hold_n_s),
        .block    (cfg_block_hold),
        .busy     (lc_busy),
        .burst_ok (burst_ok),
        .state    (state),
        .outs     (outs)
    );

    assign hold_ack_n   = outs.ack_n;
    assign bus_drive_en = outs.drive_en;
    assign lc_stall     = outs.stall;

    // R4: grant falls only after the bus has been high impedance for a cycle
    p_hiz_before_ack_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_ack_n) |-> (!bus_drive_en && !$past(bus_drive_en)));

    // R9: grant rises only after the bus has been driven again for a cycle
    p_drive_before_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_ack_n) |-> (bus_drive_en && $past(bus_drive_en)));

    // R5: drivers never turn off right after a busy cycle
    p_drain_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_drive_en) |-> !$past(lc_busy));

    // R7: a blocked block stays out of any handover
    p_block_ignores_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_block_hold && !lc_stall) |=> !lc_stall);
endmodule

// File: tb/tb_bus_hold_ctrl.sv
module tb_bus_hold_ctrl;
    localparam int HIZ = 4;
    localparam int ACK = 2;
    localparam int DRV = 2;
    localparam int REL = 2;
    localparam int MB  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req_n = 1'b1;
    logic cfg_block_hold = 1'b0;
    logic cfg_min_burst = 1'b0;
    logic lc_busy = 1'b0;
    logic lc_sdram_acc = 1'b0;
    logic hold_ack_n, bus_drive_en, lc_stall;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bus_hold_ctrl #(
        .SYNC_STAGES(2), .HIZ_DLY(HIZ), .ACK_DLY(ACK),
        .DRV_DLY(DRV), .REL_DLY(REL), .MIN_BURST(MB)
    ) dut (
        .clk(clk), .rst(rst), .hold_req_n(hold_req_n),
        .cfg_block_hold(cfg_block_hold), .cfg_min_burst(cfg_min_burst),
        .lc_busy(lc_busy), .lc_sdram_acc(lc_sdram_acc),
        .hold_ack_n(hold_ack_n), .bus_drive_en(bus_drive_en), .lc_stall(lc_stall)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic pulse_acc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) lc_sdram_acc = 1'b1;
            @(negedge clk) lc_sdram_acc = 1'b0;
        end
    endtask

    // Release sequence after a grant, shared by several scenarios
    task automatic release_and_check(string tag);
        @(negedge clk) hold_req_n = 1'b1;
        step(3);
        chk("R9", {tag, " drive still off"}, bus_drive_en, 1'b0);
        step(1);
        chk("R9", {tag, " drive back on"}, bus_drive_en, 1'b1);
        chk("R9", {tag, " ack still low"}, hold_ack_n, 1'b0);
        step(REL - 1);
        chk("R9", {tag, " ack before release"}, hold_ack_n, 1'b0);
        step(1);
        chk("R9", {tag, " ack released"}, hold_ack_n, 1'b1);
        chk("R9", {tag, " stall released"}, lc_stall, 1'b0);
    endtask

    task automatic t_reset;
        step(1);
        chk("R1", "reset ack", hold_ack_n, 1'b1);
        chk("R1", "reset drive", bus_drive_en, 1'b1);
        chk("R1", "reset stall", lc_stall, 1'b0);
    endtask

    task automatic t_basic_grant;
        @(negedge clk) hold_req_n = 1'b0;
        step(2);
        chk("R2", "stall before third edge", lc_stall, 1'b0);
        step(1);
        chk("R2", "stall on third edge", lc_stall, 1'b1);
        step(HIZ - 1);
        chk("R3", "drive before HIZ_DLY", bus_drive_en, 1'b1);
        step(1);
        chk("R3", "drive off at HIZ_DLY", bus_drive_en, 1'b0);
        chk("R4", "ack high while going hi-z", hold_ack_n, 1'b1);
        step(ACK - 1);
        chk("R4", "ack before ACK_DLY", hold_ack_n, 1'b1);
        step(1);
        chk("R4", "ack low at ACK_DLY", hold_ack_n, 1'b0);
        release_and_check("basic");
    endtask

    task automatic t_hold_kept;
        @(negedge clk) hold_req_n = 1'b0;
        step(3 + HIZ + ACK);
        chk("R8", "granted", hold_ack_n, 1'b0);
        step(25);
        chk("R8", "ack kept low", hold_ack_n, 1'b0);
        chk("R8", "drive kept off", bus_drive_en, 1'b0);
        release_and_check("kept");
    endtask

    task automatic t_busy;
        @(negedge clk) lc_busy = 1'b1;
        @(negedge clk) hold_req_n = 1'b0;
        step(20);
        chk("R5", "stall during drain", lc_stall, 1'b1);
        chk("R5", "drive on while busy", bus_drive_en, 1'b1);
        chk("R5", "ack high while busy", hold_ack_n, 1'b1);
        @(negedge clk) lc_busy = 1'b0;
        step(1);
        chk("R5", "drive off after busy drops", bus_drive_en, 1'b0);
        step(ACK);
        chk("R4", "ack low after busy drain", hold_ack_n, 1'b0);
        release_and_check("busy");
    endtask

    task automatic t_burst_on;
        @(negedge clk) cfg_min_burst = 1'b1;
        pulse_acc(3);
        @(negedge clk) hold_req_n = 1'b0;
        step(20);
        chk("R6", "drive on with partial run", bus_drive_en, 1'b1);
        chk("R6", "ack high with partial run", hold_ack_n, 1'b1);
        for (int i = 0; i < MB - 3; i++) begin
            @(negedge clk) lc_sdram_acc = 1'b1;
            step(1);
            if (i < MB - 4) chk("R6", "drive on before run complete", bus_drive_en, 1'b1);
        end
        chk("R6", "drive on at run completion edge", bus_drive_en, 1'b1);
        @(negedge clk) lc_sdram_acc = 1'b0;
        step(1);
        chk("R6", "drive off after run complete", bus_drive_en, 1'b0);
        step(ACK);
        chk("R6", "ack low after run", hold_ack_n, 1'b0);
        release_and_check("burst");
        @(negedge clk) cfg_min_burst = 1'b0;
    endtask

    task automatic t_burst_off;
        pulse_acc(3);
        @(negedge clk) hold_req_n = 1'b0;
        step(3 + HIZ);
        chk("R6", "partial run ignored when rule off", bus_drive_en, 1'b0);
        step(ACK);
        chk("R6", "ack low with rule off", hold_ack_n, 1'b0);
        release_and_check("nob");
    endtask

    task automatic t_block;
        @(negedge clk) cfg_block_hold = 1'b1;
        @(negedge clk) hold_req_n = 1'b0;
        step(30);
        chk("R7", "stall while blocked", lc_stall, 1'b0);
        chk("R7", "drive while blocked", bus_drive_en, 1'b1);
        chk("R7", "ack while blocked", hold_ack_n, 1'b1);
        @(negedge clk) hold_req_n = 1'b1;
        step(4);
        @(negedge clk) cfg_block_hold = 1'b0;
        step(4);
        chk("R7", "idle after unblock", lc_stall, 1'b0);
    endtask

    initial begin
        step(3);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_basic_grant();
        step(3);
        t_hold_kept();
        step(3);
        t_busy();
        step(3);
        t_burst_on();
        step(3);
        t_burst_off();
        step(3);
        t_block();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule